// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host-side master for a successive-approximation converter whose samples come out over a three-wire serial link. Each start request produces one conversion frame. The block pulls chip select low while the serial clock is still low. It then runs exactly sixteen serial clock periods, derived from the system clock, and shifts in the returned bits. It raises chip select, and for one cycle presents the sample right-justified on the result bus together with a done pulse.

A returned frame has four zero bits, then the sample with the most significant bit first, then zero fill up to sixteen bits. The sample can be 12, 10 or 8 bits wide, which leaves 0, 2 or 4 fill bits. The reader checks that every fill position reads as zero and reports an error with the result if one does not. After each frame, chip select stays high for a minimum quiet interval. Requests that arrive during a frame or during that interval are held and served once the interval has passed.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held and directly after it, chip select is high, the serial clock is low, done is low and no frame starts without a request.
- R2: Each frame keeps chip select low across exactly 16 rising and 16 falling serial clock edges. Chip select rises only after the 16th falling edge.
- R3: The serial clock is low whenever chip select is high, so the first serial clock edge after chip select falls is a rising edge.
- R4: Within a frame, chip select falling, each serial clock change and chip select rising are spaced exactly HALF_PERIOD system clocks apart.
- R5: The bit present when chip select falls is bit position 15. The bit launched at each falling edge is captured at the next falling edge. The 16th falling edge captures position 0. The result is positions 11 down to 12-DATA_BITS, right-justified, with position 11 as its most significant bit.
- R6: done is high for exactly one system clock, in the first cycle in which chip select is high again. The result and error outputs are valid in that cycle.
- R7: The padding error output is 1 with done when any of positions 15..12 or any position below 12-DATA_BITS captured a 1. It is 0 otherwise. The result is delivered either way.
- R8: After chip select rises, it stays high for at least QUIET_CYCLES system clocks before it falls again.
- R9: A start request that arrives during a frame or during the quiet interval is held, and a frame starts when the interval ends. Any number of such requests before that frame starts merge into one frame.
- R10: A start request seen in the idle state drives chip select low on the next system clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion frame |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select, frames one conversion |
| sclk_o | output | 1 | Serial clock, idles low |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| result_o | output | DATA_BITS | Right-justified sample |
| pad_err_o | output | 1 | A fill position read as one (valid with done) |

## Verification
A wrong bit counter shows up at the ports within one frame. It changes the number of serial clock edges seen before chip select rises. It also shifts the captured window, so the result is wrong or a fill bit falls in the data field and raises the error flag at done. A wrong divider count or state transition breaks the fixed spacing of chip select and clock edges at the first edge it affects. A lost or doubled request shows up as a missing or extra done pulse after the quiet interval. A short quiet count shows up as chip select falling too early on the next frame.

// File: rtl/afr_pkg.sv
package afr_pkg;
  localparam int FRAME_BITS = 16;
  localparam int LEAD_BITS  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RUN,
    ST_TAIL,
    ST_QUIET
  } afr_state_t;
endpackage

// File: rtl/afr_clkdiv.sv
module afr_clkdiv #(
  parameter int HALF_PERIOD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_PERIOD < 2) ? 1 : $clog2(HALF_PERIOD);
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/afr_sequencer.sv
module afr_sequencer
  import afr_pkg::*;
#(
  parameter int QUIET_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic tick,
  output logic run_en,
  output logic sample_stb,
  output logic finish_stb,
  output logic cs_n_o,
  output logic sclk_o
);
  localparam int BW = $clog2(FRAME_BITS + 1);
  localparam int QW = (QUIET_CYCLES < 2) ? 1 : $clog2(QUIET_CYCLES);
  localparam logic [BW-1:0] LAST_BIT   = BW'(FRAME_BITS - 1);
  localparam logic [QW-1:0] LAST_QUIET = QW'(QUIET_CYCLES - 1);

  afr_state_t    state;
  logic [BW-1:0] nbit;
  logic [QW-1:0] qcnt;
  logic          pend;

  assign run_en     = (state == ST_SETUP) || (state == ST_RUN) || (state == ST_TAIL);
  assign sample_stb = (state == ST_RUN) && tick && sclk_o;
  assign finish_stb = (state == ST_TAIL) && tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cs_n_o <= 1'b1;
      sclk_o <= 1'b0;
      nbit   <= '0;
      qcnt   <= '0;
      pend   <= 1'b0;
    end else begin
      if (start_i && state != ST_IDLE) pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (start_i || pend) begin
            state  <= ST_SETUP;
            cs_n_o <= 1'b0;
            pend   <= 1'b0;
            nbit   <= '0;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            sclk_o <= 1'b1;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tick) begin
            sclk_o <= ~sclk_o;
            if (sclk_o) begin
              nbit <= nbit + 1'b1;
              if (nbit == LAST_BIT) state <= ST_TAIL;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n_o <= 1'b1;
            qcnt   <= '0;
            state  <= ST_QUIET;
          end
        end
        ST_QUIET: begin
          if (qcnt == LAST_QUIET) state <= ST_IDLE;
          else qcnt <= qcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/afr_capture.sv
module afr_capture
  import afr_pkg::*;
#(
  parameter int DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_stb,
  input  logic                 finish_stb,
  input  logic                 sdata_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] result_o,
  output logic                 pad_err_o
);
  localparam int TOP   = FRAME_BITS - LEAD_BITS - 1;
  localparam int TRAIL = FRAME_BITS - LEAD_BITS - DATA_BITS;

  logic [FRAME_BITS-1:0] sh;
  logic                  lead_bad;
  logic                  trail_bad;

  assign lead_bad = |sh[FRAME_BITS-1 -: LEAD_BITS];

  generate
    if (TRAIL == 0) begin : g_no_fill
      assign trail_bad = 1'b0;
    end else begin : g_fill
      assign trail_bad = |sh[TRAIL-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      done_o    <= 1'b0;
      result_o  <= '0;
      pad_err_o <= 1'b0;
    end else begin
      done_o <= finish_stb;
      if (sample_stb) sh <= {sh[FRAME_BITS-2:0], sdata_i};
      if (finish_stb) begin
        result_o  <= sh[TOP -: DATA_BITS];
        pad_err_o <= lead_bad | trail_bad;
      end
    end
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DATA_BITS    = 12,
  parameter int HALF_PERIOD  = 2,
  parameter int QUIET_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 sdata_i,
  output logic                 cs_n_o,
  output logic                 sclk_o,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] result_o,
  output logic                 pad_err_o
);
  logic run_en;
  logic tick;
  logic sample_stb;
  logic finish_stb;

  afr_clkdiv #(.HALF_PERIOD(HALF_PERIOD)) u_div (
    .clk (clk),
    .rst (rst),
    .en  (run_en),
    .tick(tick)
  );

  afr_sequencer #(.QUIET_CYCLES(QUIET_CYCLES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .tick      (tick),
    .run_en    (run_en),
    .sample_stb(sample_stb),
    .finish_stb(finish_stb),
    .cs_n_o    (cs_n_o),
    .sclk_o    (sclk_o)
  );

  afr_capture #(.DATA_BITS(DATA_BITS)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .sample_stb(sample_stb),
    .finish_stb(finish_stb),
    .sdata_i   (sdata_i),
    .done_o    (done_o),
    .result_o  (result_o),
    .pad_err_o (pad_err_o)
  );
endmodule

// File: rtl/afr_checker.sv
module afr_checker #(
  parameter int DATA_BITS    = 12,
  parameter int HALF_PERIOD  = 2,
  parameter int QUIET_CYCLES = 4
) (
  input logic clk,
  input logic rst,
  input logic cs_n_o,
  input logic sclk_o,
  input logic done_o
);
  localparam int GW = $clog2(HALF_PERIOD + 2);
  localparam int HW = $clog2(QUIET_CYCLES + 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(HALF_PERIOD + 1);
  localparam logic [HW-1:0] HI_SAT  = HW'(QUIET_CYCLES);

  logic          cs_q, sclk_q;
  logic [GW-1:0] gap;
  logic [HW-1:0] hi_cnt;
  logic [4:0]    rises;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      gap    <= '0;
      hi_cnt <= HI_SAT;
      rises  <= '0;
    end else begin
      cs_q   <= cs_n_o;
      sclk_q <= sclk_o;
      if ((cs_n_o != cs_q) || (sclk_o != sclk_q)) gap <= GW'(1);
      else if (gap != GAP_SAT) gap <= gap + 1'b1;
      if (!cs_n_o) hi_cnt <= '0;
      else if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + 1'b1;
      if (cs_n_o && cs_q) rises <= '0;
      else if (sclk_o && !sclk_q) rises <= rises + 1'b1;
    end
  end

  // R3
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  // R4
  edge_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    ((sclk_o != sclk_q) || (cs_n_o && !cs_q)) |-> (gap == GW'(HALF_PERIOD)));

  // R2
  sixteen_rises_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n_o && !cs_q) |-> (rises == 5'd16));

  // R6
  done_at_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    done_o == (cs_n_o && !cs_q));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  quiet_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && cs_q) |-> (hi_cnt >= HI_SAT));
endmodule

bind adc_frame_reader afr_checker #(
  .DATA_BITS   (DATA_BITS),
  .HALF_PERIOD (HALF_PERIOD),
  .QUIET_CYCLES(QUIET_CYCLES)
) u_afr_chk (
  .clk   (clk),
  .rst   (rst),
  .cs_n_o(cs_n_o),
  .sclk_o(sclk_o),
  .done_o(done_o)
);

// File: tb/adc_frame_reader_bench.sv
module adc_frame_reader_bench;
  localparam int DB    = 10;
  localparam int HALF  = 2;
  localparam int QUIET = 6;
  localparam logic [15:0] FILL_MASK = 16'hF003;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          sd = 1'b0;
  logic          cs_n_o, sclk_o, done_o, pad_err_o;
  logic [DB-1:0] result_o;

  int checks = 0;
  int errors = 0;
  int dones  = 0;
  int cycles = 0;

  logic [15:0]   frame_q[$];
  logic [DB:0]   exp_q[$];
  logic [15:0]   cur;
  int            idx;

  always #2 clk = ~clk;

  adc_frame_reader #(.DATA_BITS(DB), .HALF_PERIOD(HALF), .QUIET_CYCLES(QUIET)) u_adc_frame_reader (
    .clk(clk), .rst(rst), .start_i(start), .sdata_i(sd),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .done_o(done_o),
    .result_o(result_o), .pad_err_o(pad_err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural converter: first bit at select fall, next bit at each falling clock edge.
  always @(negedge cs_n_o) begin
    cur = (frame_q.size() > 0) ? frame_q.pop_front() : 16'h0;
    idx = 0;
    sd  = cur[15];
  end
  always @(negedge sclk_o) begin
    if (cs_n_o === 1'b0) begin
      idx++;
      sd = (idx < 16) ? cur[15-idx] : 1'b0;
    end
  end
  always @(posedge cs_n_o) sd = 1'b0;

  // Driver: queue the frame the converter returns and the expected result, then pulse start.
  task automatic send(input logic [DB-1:0] data, input logic [15:0] corrupt);
    logic [15:0] fr;
    fr = {4'b0000, data, 2'b00} | (corrupt & FILL_MASK);
    frame_q.push_back(fr);
    exp_q.push_back({(|(fr & FILL_MASK)), data});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain;
    wait (exp_q.size() == 0);
    repeat (QUIET + 10) @(negedge clk);
  endtask

  // Monitor and scoreboard.
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_done = 1'b0;
  int   gap = 0, hi = 1000, rises = 0;
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      gap++;
      if (prev_cs && !cs_n_o) begin
        chk(!prev_sclk && !sclk_o, "R3", "sclk low at select fall", sclk_o, 0);
        chk(hi >= QUIET, "R8", "quiet cycles", hi, QUIET);
        rises = 0;
        gap = 0;
      end
      if (!cs_n_o && sclk_o != prev_sclk) begin
        chk(gap == HALF, "R4", "clock edge spacing", gap, HALF);
        gap = 0;
        if (sclk_o) rises++;
      end
      if (!prev_cs || !cs_n_o) begin
        if (cs_n_o && !prev_cs) begin
          chk(gap == HALF, "R4", "select rise spacing", gap, HALF);
          chk(rises == 16, "R2", "rising edges per frame", rises, 16);
          chk(done_o, "R6", "done with select rise", done_o, 1);
          hi = 0;
        end
      end
      if (cs_n_o) hi++;
      if (done_o) begin
        dones++;
        chk(!prev_done, "R6", "done width", prev_done, 0);
        if (exp_q.size() == 0) chk(0, "R9", "unexpected done", 1, 0);
        else begin
          logic [DB:0] e;
          e = exp_q.pop_front();
          chk(result_o == e[DB-1:0], "R5", "result", result_o, e[DB-1:0]);
          chk(pad_err_o == e[DB], "R7", "padding error", pad_err_o, e[DB]);
        end
      end
    end
    prev_cs = cs_n_o;
    prev_sclk = sclk_o;
    prev_done = done_o;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(cs_n_o == 1'b1, "R1", "cs_n in reset", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R1", "sclk in reset", sclk_o, 0);
    chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(cs_n_o == 1'b1, "R1", "no frame without request", cs_n_o, 1);

    // R10: select falls on the edge after an idle request
    send(10'h3FF, 16'h0);
    chk(cs_n_o == 1'b0, "R10", "cs_n after idle start", cs_n_o, 0);
    drain();

    // R5: several data patterns
    send(10'h000, 16'h0); drain();
    send(10'h2A5, 16'h0); drain();
    send(10'h155, 16'h0); drain();
    send(10'h201, 16'h0); drain();

    // R7: fill positions read as one
    send(10'h0F0, 16'h8000); drain();
    send(10'h10F, 16'h1000); drain();
    send(10'h3C3, 16'h0001); drain();
    send(10'h081, 16'h0002); drain();

    // R9: extra requests during a frame merge into one held frame
    d0 = dones;
    send(10'h1A2, 16'h0);
    repeat (10) @(negedge clk);
    send(10'h25B, 16'h0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    drain();
    chk(dones - d0 == 2, "R9", "frames for merged requests", dones - d0, 2);

    // R9 and R8: a request during the quiet interval is served after it
    d0 = dones;
    send(10'h0AA, 16'h0);
    wait (done_o === 1'b1);
    @(negedge clk);
    send(10'h355, 16'h0);
    chk(cs_n_o == 1'b1, "R9", "held during quiet", cs_n_o, 1);
    drain();
    chk(dones - d0 == 2, "R9", "quiet request served", dones - d0, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule